// File: doc/BRIEF.md
# Zero-Address Stack Processor

This block is a compact processor in which every arithmetic operand is implicit: values live on a small internal evaluation stack, and each instruction works on the entries nearest the top. Instructions come from an internal program memory indexed by the program counter. Operands are read from and written to a separate internal data memory. Both memories are filled through write ports while the core is held in reset. After the core stops, the data memory can be read back through the same address port.

Every instruction completes in one clock cycle. The instruction set covers these operations:

- push a literal, load through the top entry, and store to an address held below the top;
- add, subtract, AND and XOR on the two top entries;
- a compare that sets a two-bit condition code, which conditional jumps then read;
- an unconditional jump, call and return.

Return addresses use the operand stack. So does the interrupt entry, which saves the program counter and condition code in one stack word and jumps to a fixed vector. A stack overflow or underflow stops the core and sets a sticky fault flag.

Top module: `stack_cpu`

## Requirements
- R1: After reset, `pc` is 0, `depth` is 0, `cc` is 00, and `halted` and `fault` are both low.
- R2: An instruction word is 16 bits: the opcode is in bits 15:12 and the operand field in bits 11:0. PUSH (opcode 1) increments `depth` and places the operand, zero-extended, in the new top entry.
- R3: LOAD (opcode 2) replaces the top entry with the data-memory word addressed by the top entry. `depth` is unchanged.
- R4: STORE (opcode 3) writes the top entry to the data-memory address held in the entry below it, then removes both entries, so `depth` drops by two.
- R5: ADD, SUB, AND and XOR (opcodes 4, 5, 6, 7) combine the entry below the top, as the left operand, with the top entry. The result, modulo 2^16, replaces both entries, so `depth` drops by one.
- R6: CMP (opcode 8) compares the two top entries as unsigned numbers and leaves the stack unchanged. It sets `cc` to 00 when they are equal, to 01 when the lower entry is greater, and to 11 when the lower entry is smaller.
- R7: JMP (opcode 9) loads `pc` with operand bits 7:0. JCC (opcode 10) does the same only when `cc` satisfies the relation selected by operand bits 11:9: 0 equal, 1 not equal, 2 less, 3 less-or-equal, 4 greater, 5 greater-or-equal. Otherwise `pc` advances by one.
- R8: CALL (opcode 11) pushes the address of the next instruction and jumps to operand bits 7:0. RET (opcode 12) pops the top entry into `pc`.
- R9: A high `irq` is taken at an instruction boundary when no handler is active. Instead of executing the instruction at `pc`, the core pushes one word holding `cc` in bits 15:14 and `pc` in bits 7:0, then jumps to address 0x80. Further requests are ignored until RETI (opcode 13), which pops that word and restores both `pc` and `cc`.
- R10: An instruction that would push onto a full 16-entry stack, or pop more entries than the stack holds, changes nothing except to raise `fault` and `halted`. Both stay high until reset.
- R11: HALT (opcode 0) raises `halted`. From then on `pc`, `depth` and `cc` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq | input | 1 | Interrupt request, level sensitive |
| pm_we | input | 1 | Program memory write enable |
| pm_addr | input | 8 | Program memory write address |
| pm_wdata | input | 16 | Program memory write data |
| dm_we | input | 1 | Data memory write enable (external preload) |
| dm_addr | input | 6 | Data memory external address, for both write and read |
| dm_wdata | input | 16 | Data memory external write data |
| dm_rdata | output | 16 | Data memory word at `dm_addr` |
| halted | output | 1 | Core stopped by HALT or fault |
| fault | output | 1 | Sticky stack overflow or underflow flag |
| pc | output | 8 | Program counter |
| depth | output | 5 | Number of occupied stack entries |
| cc | output | 2 | Condition code |

## Verification
A wrong stack pointer shows on `depth` in the cycle after the instruction that moved it. A few cycles later it also reaches the data memory, because a later STORE then writes the wrong value or writes to the wrong address. A corrupted condition code shows directly on `cc` and, one cycle later, as a wrong `pc` after a conditional jump. A bad return word saved at interrupt entry or CALL shows only when RET or RETI executes. For that reason the tests inspect data-memory markers and the final `cc` that are only produced after control has returned.

// File: rtl/stack_cpu.sv
module stack_cpu #(
  parameter int DW      = 16,
  parameter int PAW     = 8,
  parameter int DAW     = 6,
  parameter int SDEPTH  = 16,
  parameter int IRQ_VEC = 8'h80
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           irq,
  input  logic           pm_we,
  input  logic [PAW-1:0] pm_addr,
  input  logic [15:0]    pm_wdata,
  input  logic           dm_we,
  input  logic [DAW-1:0] dm_addr,
  input  logic [DW-1:0]  dm_wdata,
  output logic [DW-1:0]  dm_rdata,
  output logic           halted,
  output logic           fault,
  output logic [PAW-1:0] pc,
  output logic [$clog2(SDEPTH+1)-1:0] depth,
  output logic [1:0]     cc
);
  localparam int SPW = $clog2(SDEPTH+1);
  localparam int SIW = $clog2(SDEPTH);
  localparam int PDEPTH = 1 << PAW;
  localparam int DDEPTH = 1 << DAW;

  typedef enum logic [3:0] {
    OP_HALT = 4'd0, OP_PUSH = 4'd1, OP_LOAD = 4'd2, OP_STORE = 4'd3,
    OP_ADD  = 4'd4, OP_SUB  = 4'd5, OP_AND  = 4'd6, OP_XOR   = 4'd7,
    OP_CMP  = 4'd8, OP_JMP  = 4'd9, OP_JCC  = 4'd10, OP_CALL = 4'd11,
    OP_RET  = 4'd12, OP_RETI = 4'd13
  } op_e;

  logic [15:0]   pmem [PDEPTH];
  logic [DW-1:0] dmem [DDEPTH];
  logic [DW-1:0] stk  [SDEPTH];
  logic          in_isr;

  logic [15:0]    ir;
  logic [3:0]     op;
  logic [11:0]    imm;
  logic [SPW-1:0] tix, nix;
  logic [DW-1:0]  top, below, alu, lit;
  logic [PAW-1:0] pc_nx, tgt;
  logic [1:0]     cmp_cc;
  logic           take_irq, need1, need2, grows, err, cond_ok, run;
  logic           stk_we, cpu_st;
  logic [SIW-1:0] stk_wix;
  logic [DW-1:0]  stk_wd;

  assign ir    = pmem[pc];
  assign op    = ir[15:12];
  assign imm   = ir[11:0];
  assign tgt   = imm[PAW-1:0];
  assign pc_nx = pc + 1'b1;
  assign lit   = {{(DW-12){1'b0}}, imm};
  assign tix   = depth - 1'b1;
  assign nix   = depth - 2'd2;
  assign top   = stk[tix[SIW-1:0]];
  assign below = stk[nix[SIW-1:0]];

  assign take_irq = irq && !in_isr;
  assign need1 = op == OP_LOAD || op == OP_RET || op == OP_RETI;
  assign need2 = op == OP_STORE || op == OP_CMP ||
                 (op >= OP_ADD && op <= OP_XOR);
  assign grows = op == OP_PUSH || op == OP_CALL;
  assign err = take_irq ? (depth == SPW'(SDEPTH))
                        : ((need2 && depth < 2) || (need1 && depth == 0) ||
                           (grows && depth == SPW'(SDEPTH)));
  assign run    = !halted && !err;
  assign cpu_st = run && !take_irq && op == OP_STORE;

  assign cmp_cc = (below == top) ? 2'b00 : (below > top) ? 2'b01 : 2'b11;

  always_comb begin
    case (op)
      OP_ADD:  alu = below + top;
      OP_SUB:  alu = below - top;
      OP_AND:  alu = below & top;
      default: alu = below ^ top;
    endcase
  end

  always_comb begin
    case (imm[11:9])
      3'd0:    cond_ok = cc == 2'b00;
      3'd1:    cond_ok = cc != 2'b00;
      3'd2:    cond_ok = cc == 2'b11;
      3'd3:    cond_ok = cc != 2'b01;
      3'd4:    cond_ok = cc == 2'b01;
      3'd5:    cond_ok = cc != 2'b11;
      default: cond_ok = 1'b0;
    endcase
  end

  always_comb begin
    stk_we  = 1'b0;
    stk_wix = depth[SIW-1:0];
    stk_wd  = lit;
    if (run) begin
      if (take_irq) begin
        stk_we = 1'b1;
        stk_wd = {cc, {(DW-2-PAW){1'b0}}, pc};
      end else begin
        case (op)
          OP_PUSH: stk_we = 1'b1;
          OP_CALL: begin stk_we = 1'b1; stk_wd = {{(DW-PAW){1'b0}}, pc_nx}; end
          OP_LOAD: begin stk_we = 1'b1; stk_wix = tix[SIW-1:0]; stk_wd = dmem[top[DAW-1:0]]; end
          OP_ADD, OP_SUB, OP_AND, OP_XOR:
                   begin stk_we = 1'b1; stk_wix = nix[SIW-1:0]; stk_wd = alu; end
          default: stk_we = 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stk_we) stk[stk_wix] <= stk_wd;
  end

  always_ff @(posedge clk) begin
    if (pm_we) pmem[pm_addr] <= pm_wdata;
  end

  always_ff @(posedge clk) begin
    if (dm_we)       dmem[dm_addr] <= dm_wdata;
    else if (cpu_st) dmem[below[DAW-1:0]] <= top;
  end

  assign dm_rdata = dmem[dm_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0; depth <= '0; cc <= 2'b00;
      halted <= 1'b0; fault <= 1'b0; in_isr <= 1'b0;
    end else if (!halted) begin
      if (err) begin
        fault  <= 1'b1;
        halted <= 1'b1;
      end else if (take_irq) begin
        depth  <= depth + 1'b1;
        pc     <= PAW'(IRQ_VEC);
        in_isr <= 1'b1;
      end else begin
        pc <= pc_nx;
        case (op)
          OP_HALT:  begin halted <= 1'b1; pc <= pc; end
          OP_PUSH:  depth <= depth + 1'b1;
          OP_STORE: depth <= depth - 2'd2;
          OP_ADD, OP_SUB, OP_AND, OP_XOR: depth <= depth - 1'b1;
          OP_CMP:   cc <= cmp_cc;
          OP_JMP:   pc <= tgt;
          OP_JCC:   if (cond_ok) pc <= tgt;
          OP_CALL:  begin depth <= depth + 1'b1; pc <= tgt; end
          OP_RET:   begin depth <= depth - 1'b1; pc <= top[PAW-1:0]; end
          OP_RETI:  begin
            depth <= depth - 1'b1; pc <= top[PAW-1:0];
            cc <= top[DW-1:DW-2]; in_isr <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  AST_DEPTH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) depth <= SPW'(SDEPTH)); // R10
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) fault |=> fault && halted); // R10
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(pc) && $stable(depth) && $stable(cc)); // R11
  AST_IRQ_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (run && take_irq) |=> pc == PAW'(IRQ_VEC) && depth == SPW'($past(depth) + 1'b1)); // R9
  AST_STORE_POP: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_st |=> depth == SPW'($past(depth) - 2'd2)); // R4
  AST_CC_CODE: assert property (@(posedge clk) disable iff (!rst_n) cc != 2'b10); // R6
endmodule

// File: tb/stack_cpu_tb.sv
module stack_cpu_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, irq = 1'b0;
  logic pm_we = 1'b0, dm_we = 1'b0;
  logic [7:0] pm_addr = '0;
  logic [15:0] pm_wdata = '0, dm_wdata = '0, dm_rdata;
  logic [5:0] dm_addr = '0;
  logic halted, fault;
  logic [7:0] pc;
  logic [4:0] depth;
  logic [1:0] cc;
  int n_tests = 0, n_fail = 0, cycles = 0;

  stack_cpu u_dut (.clk(clk), .rst_n(rst_n), .irq(irq), .pm_we(pm_we), .pm_addr(pm_addr),
    .pm_wdata(pm_wdata), .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata),
    .dm_rdata(dm_rdata), .halted(halted), .fault(fault), .pc(pc), .depth(depth), .cc(cc));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_fail = n_fail + 1; n_tests = n_tests + 1;
      $display("FAIL watchdog: run hung (act cycles=%0d, exp < 150000)", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] imm);
    return {op, imm};
  endfunction
  function automatic logic [15:0] jcc(input logic [2:0] c, input logic [7:0] t);
    return {4'hA, c, 1'b0, t};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pw(input int a, input logic [15:0] w);
    pm_we = 1'b1; pm_addr = a[7:0]; pm_wdata = w;
    tick(1);
    pm_we = 1'b0;
  endtask

  task automatic dw(input int a, input logic [15:0] w);
    dm_we = 1'b1; dm_addr = a[5:0]; dm_wdata = w;
    tick(1);
    dm_we = 1'b0;
  endtask

  function automatic logic [15:0] dr(input int a);
    dm_addr = a[5:0];
    return dm_rdata;
  endfunction

  task automatic fresh();
    rst_n = 1'b0; irq = 1'b0;
    tick(1);
    for (int i = 0; i < 256; i++) pw(i, 16'h0000);
  endtask

  task automatic go();
    rst_n = 1'b1;
  endtask

  task automatic run_to_halt();
    for (int i = 0; i < 400 && !halted; i++) tick(1);
  endtask

  task automatic t_reset();
    fresh();
    chk("R1 pc", pc, 0); chk("R1 depth", depth, 0); chk("R1 cc", cc, 0);
    chk("R1 halted", halted, 0); chk("R1 fault", fault, 0);
  endtask

  task automatic t_mem();
    fresh();
    dw(5, 16'h1234);
    pw(0, ins(1, 20)); pw(1, ins(1, 5)); pw(2, ins(2, 0)); pw(3, ins(3, 0));
    pw(4, ins(1, 21)); pw(5, ins(1, 12'hABC)); pw(6, ins(3, 0)); pw(7, ins(0, 0));
    go();
    tick(1); chk("R2 depth after push", depth, 1);
    tick(2); chk("R3 depth after load", depth, 2);
    tick(1); chk("R4 depth after store", depth, 0);
    run_to_halt();
    chk("R3 loaded word", dr(20), 16'h1234);
    chk("R2 literal zero-extended", dr(21), 16'h0ABC);
    chk("R11 halted", halted, 1);
    chk("R11 pc at halt", pc, 7);
    tick(3);
    chk("R11 pc frozen", pc, 7);
    chk("R11 depth frozen", depth, 0);
  endtask

  task automatic t_alu();
    fresh();
    pw(0, ins(1, 30)); pw(1, ins(1, 7));     pw(2, ins(1, 10));   pw(3, ins(5, 0)); pw(4, ins(3, 0));
    pw(5, ins(1, 31)); pw(6, ins(1, 12'hFFF)); pw(7, ins(1, 12'h00F)); pw(8, ins(6, 0)); pw(9, ins(3, 0));
    pw(10, ins(1, 32)); pw(11, ins(1, 12'h0F0)); pw(12, ins(1, 12'h0FF)); pw(13, ins(7, 0)); pw(14, ins(3, 0));
    pw(15, ins(1, 33)); pw(16, ins(1, 12'hFFF)); pw(17, ins(1, 12'hFFF)); pw(18, ins(4, 0)); pw(19, ins(3, 0));
    pw(20, ins(0, 0));
    go();
    tick(4); chk("R5 depth after sub", depth, 2);
    run_to_halt();
    chk("R5 sub order and wrap", dr(30), 16'hFFFD);
    chk("R5 and", dr(31), 16'h000F);
    chk("R5 xor", dr(32), 16'h000F);
    chk("R5 add", dr(33), 16'h1FFE);
  endtask

  task automatic t_jcc(input int a, input int b, input int c);
    logic [1:0] ecc;
    logic take;
    ecc = (a == b) ? 2'b00 : (a > b) ? 2'b01 : 2'b11;
    case (c)
      0: take = (a == b);  1: take = (a != b);
      2: take = (a < b);   3: take = (a <= b);
      4: take = (a > b);   default: take = (a >= b);
    endcase
    fresh();
    pw(0, ins(1, a[11:0])); pw(1, ins(1, b[11:0])); pw(2, ins(8, 0));
    pw(3, jcc(c[2:0], 7)); pw(4, ins(1, 50)); pw(5, ins(1, 0)); pw(6, ins(9, 9));
    pw(7, ins(1, 50)); pw(8, ins(1, 1)); pw(9, ins(3, 0)); pw(10, ins(0, 0));
    go();
    tick(3);
    chk("R6 cc code", cc, ecc);
    chk("R6 cmp keeps depth", depth, 2);
    run_to_halt();
    chk("R7 branch outcome", dr(50), take);
    chk("R7 depth at end", depth, 2);
  endtask

  task automatic t_call();
    fresh();
    pw(0, ins(1, 61)); pw(1, ins(11, 3)); pw(2, ins(0, 0)); pw(3, ins(3, 0)); pw(4, ins(0, 0));
    go();
    tick(2);
    chk("R8 call target", pc, 3);
    chk("R8 call depth", depth, 2);
    run_to_halt();
    chk("R8 pushed return address", dr(61), 2);
    fresh();
    pw(0, ins(1, 60)); pw(1, ins(11, 10)); pw(2, ins(1, 7)); pw(3, ins(3, 0)); pw(4, ins(0, 0));
    pw(10, ins(12, 0));
    go();
    tick(3);
    chk("R8 ret pc", pc, 2);
    chk("R8 ret depth", depth, 1);
    run_to_halt();
    chk("R8 resumed after return", dr(60), 7);
    chk("R8 halt pc", pc, 4);
  endtask

  task automatic t_irq();
    fresh();
    pw(0, ins(1, 9)); pw(1, ins(1, 3)); pw(2, ins(8, 0)); pw(3, ins(9, 4));
    pw(4, jcc(3'd4, 6)); pw(5, ins(0, 0)); pw(6, ins(1, 40)); pw(7, ins(1, 77));
    pw(8, ins(3, 0)); pw(9, ins(0, 0));
    pw(8'h80, ins(1, 1)); pw(8'h81, ins(1, 2)); pw(8'h82, ins(8, 0));
    pw(8'h83, ins(3, 0)); pw(8'h84, ins(13, 0));
    dw(40, 0); dw(1, 0);
    go();
    tick(3);
    irq = 1'b1;
    tick(1);
    chk("R9 vector", pc, 8'h80);
    chk("R9 entry push", depth, 3);
    tick(2);
    chk("R9 masked while active", pc, 8'h82);
    irq = 1'b0;
    run_to_halt();
    chk("R9 handler ran", dr(1), 2);
    chk("R9 cc restored", cc, 2'b01);
    chk("R9 returned and branched", dr(40), 77);
    chk("R9 final depth", depth, 2);
    chk("R9 no fault", fault, 0);
  endtask

  task automatic t_fault();
    fresh();
    pw(0, ins(4, 0));
    go();
    tick(1);
    chk("R10 underflow fault", fault, 1);
    chk("R10 underflow halted", halted, 1);
    chk("R10 underflow depth", depth, 0);
    chk("R10 underflow pc", pc, 0);
    fresh();
    for (int i = 0; i < 17; i++) pw(i, ins(1, 1));
    go();
    tick(16);
    chk("R10 full no fault", fault, 0);
    tick(1);
    chk("R10 overflow fault", fault, 1);
    chk("R10 overflow depth", depth, 16);
    chk("R10 overflow pc", pc, 16);
    tick(3);
    chk("R10 fault sticky", fault, 1);
    chk("R10 pc held", pc, 16);
  endtask

  initial begin
    t_reset();
    t_mem();
    t_alu();
    for (int c = 0; c < 6; c++) begin
      t_jcc(5, 5, c);
      t_jcc(3, 9, c);
      t_jcc(9, 3, c);
    end
    t_call();
    t_irq();
    t_fault();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule